// File: doc/BRIEF.md
# Three-Port GPIO Register Controller

This block holds the configuration of three eight-bit general-purpose I/O ports behind a small synchronous register bus. Each port has three byte registers: a data latch, a direction mask and a drive option mask. From these it computes, per pin, the latch value, an enable for the pull-down (low-side) driver and an enable for the pull-up (high-side) driver. A pin can be an input, a push-pull output or an open-drain output. The pad buffers, pull-ups, interrupts and analog paths sit outside and are not part of it.

Pin levels come in asynchronously and pass through a two-stage synchronizer. A read of a data register returns the latch for output pins and the synchronized level for input pins. For input pins, the data and option bits are passed out unchanged as raw configuration signals. This lets the surrounding logic choose the input circuit.

Top module: `tri_port_gpio`

## Requirements
- R1: After rst_ni is released, all nine registers read 00h, every pin is an input, and all drive enables and configuration outputs are 0.
- R2: Address map, with p = 0, 1, 2 for ports A, B, C: the data register of port p is at C0h+p, the direction register at C4h+p and the option register at CCh+p. All are read/write.
- R3: Direction bit 0 makes the pin an input, with both drive enables at 0. Direction bit 1 makes it an output.
- R4: An output pin whose option bit is 1 is push-pull. hs_en is 1 when the latch bit is 1, and ls_en is 1 when the latch bit is 0.
- R5: An output pin whose option bit is 0 is open-drain. hs_en stays 0 and ls_en equals the inverted latch bit. hs_en and ls_en are never both 1.
- R6: On a data register read, each bit returns the latch bit if the pin is an output, or the synchronized pin level if the pin is an input.
- R7: cfg_data_o and cfg_opt_o carry the data and option bits for input pins and 0 for output pins. They follow a register write in the cycle after the write edge.
- R8: Read data appears on rdata_o one cycle after the cycle in which re_i is sampled. A change on pin_i is first visible to a read that is sampled on the third clock edge after the change.
- R9: Reads from unmapped addresses (for example C3h, C7h, C8h or 00h) return 00h. Writes to unmapped addresses change no register and no output.
- R10: A data register that is read and then written back unchanged stores the sampled levels of its input pins into their latch bits. These bits then appear on cfg_data_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| pin_i | input | 24 | Pin levels, port A in bits 7:0, B in 15:8, C in 23:16 |
| out_val_o | output | 24 | Data latch value per pin |
| ls_en_o | output | 24 | Low-side (pull-down) driver enable |
| hs_en_o | output | 24 | High-side (pull-up) driver enable |
| cfg_data_o | output | 24 | Data bit of input pins, 0 for outputs |
| cfg_opt_o | output | 24 | Option bit of input pins, 0 for outputs |

## Verification
Drive enables and configuration outputs depend on the registers through logic only. The bench therefore checks them at the falling edge right after the write edge. Read data is registered, so a read sampled at one rising edge is compared at the next falling edge: the driver task queues the expected byte when it raises re_i, and the monitor pops it one cycle later. Pin changes are applied at a falling edge, and back-to-back reads expect the old level on the first two edges and the new level on the third. This confirms the two-flop delay.

// File: rtl/tri_port_gpio_pkg.sv
package tri_port_gpio_pkg;
  // register kind, decoded from addr[3:2]
  typedef enum logic [1:0] {
    KIND_DATA = 2'b00,
    KIND_DIR  = 2'b01,
    KIND_NONE = 2'b10,
    KIND_OPT  = 2'b11
  } reg_kind_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_data_i,
  input  logic         wr_dir_i,
  input  logic         wr_opt_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] pin_sync_i,
  output logic [W-1:0] rd_data_o,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] opt_o,
  output logic [W-1:0] out_val_o,
  output logic [W-1:0] ls_en_o,
  output logic [W-1:0] hs_en_o,
  output logic [W-1:0] cfg_data_o,
  output logic [W-1:0] cfg_opt_o
);
  logic [W-1:0] data_q, dir_q, opt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= '0;
      opt_q  <= '0;
    end else begin
      if (wr_data_i) data_q <= wdata_i;
      if (wr_dir_i)  dir_q  <= wdata_i;
      if (wr_opt_i)  opt_q  <= wdata_i;
    end
  end

  // per-pin drive: inputs float, open-drain never drives high
  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb begin
      hs_en_o[i] = 1'b0;
      ls_en_o[i] = 1'b0;
      if (dir_q[i]) begin
        ls_en_o[i] = ~data_q[i];
        hs_en_o[i] = opt_q[i] & data_q[i];
      end
    end
  end

  assign rd_data_o  = (dir_q & data_q) | (~dir_q & pin_sync_i);
  assign dir_o      = dir_q;
  assign opt_o      = opt_q;
  assign out_val_o  = data_q;
  assign cfg_data_o = data_q & ~dir_q;
  assign cfg_opt_o  = opt_q & ~dir_q;

  assert_no_contention_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_en_o & ls_en_o) == '0);
  assert_od_no_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_en_o & ~(dir_q & opt_q)) == '0);
  assert_input_floats_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hs_en_o | ls_en_o) & ~dir_q) == '0);
  assert_dir_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dir_i |=> dir_q == $past(wdata_i));
  assert_cfg_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_opt_i |=> (cfg_opt_o | dir_q) == ($past(wdata_i) | dir_q));
endmodule

// File: rtl/tri_port_gpio.sv
module tri_port_gpio
  import tri_port_gpio_pkg::*;
#(
  parameter int          NUM_PORTS = 3,
  parameter int          PORT_W    = 8,
  parameter int          ADDR_W    = 8,
  parameter logic [3:0]  BASE_PAGE = 4'hC
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [PORT_W-1:0]           wdata_i,
  input  logic                        we_i,
  input  logic                        re_i,
  output logic [PORT_W-1:0]           rdata_o,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_i,
  output logic [NUM_PORTS*PORT_W-1:0] out_val_o,
  output logic [NUM_PORTS*PORT_W-1:0] ls_en_o,
  output logic [NUM_PORTS*PORT_W-1:0] hs_en_o,
  output logic [NUM_PORTS*PORT_W-1:0] cfg_data_o,
  output logic [NUM_PORTS*PORT_W-1:0] cfg_opt_o
);
  localparam int PAGE_W = ADDR_W - 4;

  logic [NUM_PORTS*PORT_W-1:0] pin_sync;
  logic [PORT_W-1:0] rd_data [NUM_PORTS];
  logic [PORT_W-1:0] rd_dir  [NUM_PORTS];
  logic [PORT_W-1:0] rd_opt  [NUM_PORTS];
  logic [NUM_PORTS-1:0] sel;
  logic       page_hit, mapped;
  reg_kind_e  kind;
  logic [PORT_W-1:0] rd_mux;

  assign page_hit = addr_i[ADDR_W-1:4] == PAGE_W'(BASE_PAGE);
  assign kind     = reg_kind_e'(addr_i[3:2]);
  assign mapped   = page_hit && (kind != KIND_NONE) && (|sel);

  gpio_sync #(.W(NUM_PORTS*PORT_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign sel[p] = page_hit && (addr_i[1:0] == 2'(p));

    gpio_port #(.W(PORT_W)) u_port (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_data_i (we_i && sel[p] && kind == KIND_DATA),
      .wr_dir_i  (we_i && sel[p] && kind == KIND_DIR),
      .wr_opt_i  (we_i && sel[p] && kind == KIND_OPT),
      .wdata_i   (wdata_i),
      .pin_sync_i(pin_sync[p*PORT_W +: PORT_W]),
      .rd_data_o (rd_data[p]),
      .dir_o     (rd_dir[p]),
      .opt_o     (rd_opt[p]),
      .out_val_o (out_val_o[p*PORT_W +: PORT_W]),
      .ls_en_o   (ls_en_o[p*PORT_W +: PORT_W]),
      .hs_en_o   (hs_en_o[p*PORT_W +: PORT_W]),
      .cfg_data_o(cfg_data_o[p*PORT_W +: PORT_W]),
      .cfg_opt_o (cfg_opt_o[p*PORT_W +: PORT_W])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (sel[p]) begin
        case (kind)
          KIND_DATA: rd_mux = rd_data[p];
          KIND_DIR:  rd_mux = rd_dir[p];
          KIND_OPT:  rd_mux = rd_opt[p];
          default:   rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_mux;
  end

  assert_unmapped_reads_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !mapped) |=> rdata_o == '0);
  assert_rdata_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

// File: tb/tri_port_gpio_test.sv
module tri_port_gpio_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [7:0]  rdata;
  logic [23:0] pins = '0;
  logic [23:0] out_val, ls_en, hs_en, cfg_data, cfg_opt;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  tri_port_gpio uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .pin_i(pins),
    .out_val_o(out_val), .ls_en_o(ls_en), .hs_en_o(hs_en),
    .cfg_data_o(cfg_data), .cfg_opt_o(cfg_opt)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  // driver: queue expectation, strobe read for one cycle
  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
  endtask

  always @(posedge clk) rd_seen <= re;

  // monitor: result is due one cycle after the read edge
  always @(negedge clk) begin
    if (rd_seen && rst_n) begin
      if (exp_q.size() == 0) check("R8 unexpected read", 1, 0);
      else check(tag_q.pop_front(), {24'h0, rdata}, {24'h0, exp_q.pop_front()});
    end
  end

  function automatic logic [7:0] pb(input logic [23:0] v, input int p);
    return v[p*8 +: 8];
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", {24'h0, rdata}, 0);
    check("R1 drivers", ls_en | hs_en, 0);
    check("R1 cfg", cfg_data | cfg_opt | out_val, 0);
    for (int p = 0; p < 3; p++) begin
      rd(8'hC0 + 8'(p), 8'h00, "R1 data reset");
      rd(8'hC4 + 8'(p), 8'h00, "R1 dir reset");
      rd(8'hCC + 8'(p), 8'h00, "R1 opt reset");
    end

    // R2 R4 port A push-pull
    wr(8'hC4, 8'hFF);
    wr(8'hCC, 8'hFF);
    wr(8'hC0, 8'hA5);
    check("R4 hs A", pb(hs_en, 0), 8'hA5);
    check("R4 ls A", pb(ls_en, 0), 8'h5A);
    check("R4 out A", pb(out_val, 0), 8'hA5);
    check("R7 cfg A all output", pb(cfg_data, 0) | pb(cfg_opt, 0), 0);
    rd(8'hC0, 8'hA5, "R6 data A output");
    rd(8'hC4, 8'hFF, "R2 dir A");
    rd(8'hCC, 8'hFF, "R2 opt A");

    // R5 port B open-drain
    wr(8'hC5, 8'hFF);
    wr(8'hC1, 8'h3C);
    check("R5 hs B", pb(hs_en, 1), 8'h00);
    check("R5 ls B", pb(ls_en, 1), 8'hC3);
    check("R2 port A untouched", pb(hs_en, 0), 8'hA5);

    // R6 R7 port C mixed: upper nibble output open-drain, lower input
    pins[23:16] = 8'h96;
    wr(8'hC6, 8'hF0);
    wr(8'hCE, 8'h0F);
    wr(8'hC2, 8'h5A);
    check("R7 cfg data C", pb(cfg_data, 2), 8'h0A);
    check("R7 cfg opt C", pb(cfg_opt, 2), 8'h0F);
    check("R5 ls C", pb(ls_en, 2), 8'hA0);
    check("R3 hs C", pb(hs_en, 2), 8'h00);
    rd(8'hC2, 8'h56, "R6 data C mixed");

    // R8 synchronizer: old, old, new
    pins[23:16] = 8'h69;
    rd(8'hC2, 8'h56, "R8 edge0 old level");
    rd(8'hC2, 8'h56, "R8 edge1 old level");
    rd(8'hC2, 8'h59, "R8 edge2 new level");

    // R9 unmapped
    wr(8'hC8, 8'hFF);
    wr(8'hC3, 8'hFF);
    wr(8'hC7, 8'hFF);
    wr(8'h40, 8'hFF);
    check("R9 hs unchanged", hs_en, {8'h00, 8'h00, 8'hA5});
    check("R9 ls unchanged", ls_en, {8'hA0, 8'hC3, 8'h5A});
    check("R9 cfg unchanged", cfg_data, {8'h0A, 8'h00, 8'h00});
    rd(8'hC8, 8'h00, "R9 read C8");
    rd(8'hC7, 8'h00, "R9 read C7");
    rd(8'hC3, 8'h00, "R9 read C3");
    rd(8'h00, 8'h00, "R9 read 00");
    rd(8'hC5, 8'hFF, "R9 dir B intact");

    // R10 read-modify-write stores pin levels
    rd(8'hC2, 8'h59, "R10 read back C");
    @(negedge clk);
    wr(8'hC2, 8'h59);
    check("R10 cfg data C", pb(cfg_data, 2), 8'h09);
    check("R10 out C", pb(out_val, 2), 8'h59);

    // R3 port A back to input
    pins[7:0] = 8'h33;
    wr(8'hC4, 8'h00);
    check("R3 drivers off A", pb(hs_en, 0) | pb(ls_en, 0), 0);
    check("R7 cfg data A", pb(cfg_data, 0), 8'hA5);
    check("R7 cfg opt A", pb(cfg_opt, 0), 8'hFF);
    @(negedge clk);
    rd(8'hC0, 8'h33, "R3 data A reads pins");

    repeat (3) @(negedge clk);
    check("R8 queue drained", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule